// File: doc/BRIEF.md
# Gigabit Ethernet Idle Ordered-Set Converter

This block sits in the transmit path of a 1000BASE-X physical coding sublayer, just ahead of the 8B/10B encoder. Code groups arrive one per valid cycle as an 8-bit value with a control flag. They are grouped into two-group ordered sets, and a set can start only on an even code-group position. When an even position carries the comma control code K28.5 and the next valid code group is a data code, the pair is treated as an idle. The block then replaces the data code so that the encoder's running disparity is negative once the idle has been sent.

The choice depends on the running disparity reported by the downstream encoder after it has encoded the K28.5. If the disparity is negative, the second group becomes D5.6 (0xC5), which is neutral, and the pair is /I1/. If the disparity is positive, the second group becomes D16.2 (0x50), which ends negative, and the pair is /I2/. Configuration ordered sets are never changed. A configuration set is recognised in two ways: by a flag raised while configuration is being sent, and by its second code D21.5 (0xB5) or D2.2 (0x42). All other traffic passes through bit for bit, one cycle later.

Top module: `idle_os_converter`

## Requirements
- R1: While reset is high, and in the first cycle after it drops, out_valid, out_k and out_data are all zero. The position counter restarts at even.
- R2: Each output appears exactly one clock after its input. out_valid equals in_valid from the previous cycle, and when out_valid is high, out_k equals the previous in_k.
- R3: A pair is an idle when in_k=1 with in_data=0xBC on an even position of the valid stream is followed by a valid code group with in_k=0. Only the data group of an idle is rewritten.
- R4: When an idle's data group is accepted with rd_pos=0 (negative disparity after the comma), the block outputs 0xC5 (D5.6) with out_k=0.
- R5: When an idle's data group is accepted with rd_pos=1 (positive disparity), the block outputs 0x50 (D16.2) with out_k=0.
- R6: A second group of 0xB5 (D21.5) or 0x42 (D2.2) after an even comma passes unchanged.
- R7: A second group accepted while cfg_active=1 passes unchanged, whatever its value.
- R8: A 0xBC comma on an odd position does not start an ordered set. It passes unchanged, and so does the group after it.
- R9: Every other data and control code group reaches out_data bit for bit. This includes a control group that follows an even comma.
- R10: Cycles with in_valid=0 neither advance the position nor break the pairing of a comma with its next valid group.
- R11: The comma of an idle itself is output unchanged (0xBC, out_k=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code-group clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A code group is present on in_k/in_data |
| in_k | input | 1 | 1 = control code group, 0 = data code group |
| in_data | input | 8 | Code group value (HGF_EDCBA bit order) |
| cfg_active | input | 1 | Configuration ordered sets are being sent; suppresses rewriting |
| rd_pos | input | 1 | Encoder running disparity after the last emitted group: 1 positive, 0 negative |
| out_valid | output | 1 | Output code group present |
| out_k | output | 1 | Control flag of the output code group |
| out_data | output | 8 | Output code group value |

## Verification
A wrong internal position bit shows up at the ports on the first even/odd pairing that follows. The symptoms are an idle whose data group passes untouched, or a rewrite after a comma on an odd position, and they appear one cycle after the second group enters. A stuck or stale pairing flag shows as a data group rewritten to 0xC5 or 0x50 without an even comma ahead of it, or as a missed rewrite. Gaps in the valid stream are placed between commas and their partners so that such faults become visible. The reference model tracks position and pairing on its own and compares every output cycle, so a wrong disparity choice or a touched configuration set is reported within one clock.

// File: rtl/idle_conv_pkg.sv
package idle_conv_pkg;

    localparam int CG_W = 8;

    typedef logic [CG_W-1:0] cg_byte_t;

    typedef struct packed {
        logic     k;
        cg_byte_t d;
    } code_group_t;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } cg_phase_e;

    localparam cg_byte_t CG_COMMA   = 8'hBC; // K28.5
    localparam cg_byte_t CG_IDLE_N  = 8'hC5; // D5.6, neutral
    localparam cg_byte_t CG_IDLE_P  = 8'h50; // D16.2, ends negative
    localparam cg_byte_t CG_CFG_ONE = 8'hB5; // D21.5
    localparam cg_byte_t CG_CFG_TWO = 8'h42; // D2.2

    function automatic logic is_comma(input code_group_t cg);
        return cg.k && (cg.d == CG_COMMA);
    endfunction

    function automatic logic is_cfg_code(input cg_byte_t d);
        return (d == CG_CFG_ONE) || (d == CG_CFG_TWO);
    endfunction

    function automatic cg_byte_t idle_second(input logic disp_pos);
        return disp_pos ? CG_IDLE_P : CG_IDLE_N;
    endfunction

endpackage

// File: rtl/idle_phase_track.sv
module idle_phase_track
    import idle_conv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    output cg_phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_EVEN;
        end else if (adv) begin
            phase <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
        end
    end
endmodule

// File: rtl/idle_pair_detect.sv
module idle_pair_detect
    import idle_conv_pkg::*;
#(
    parameter bit GUARD_CFG_CODES = 1'b1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cg_valid,
    input  code_group_t cg,
    input  cg_phase_e   phase,
    input  logic        cfg_active,
    output logic        rewrite
);
    logic armed;
    logic code_guard;

    generate
        if (GUARD_CFG_CODES) begin : g_code_guard
            assign code_guard = is_cfg_code(cg.d);
        end else begin : g_no_code_guard
            assign code_guard = 1'b0;
        end
    endgenerate

    always_comb begin
        rewrite = cg_valid && armed && !cg.k && !cfg_active && !code_guard;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (cg_valid) begin
            armed <= (phase == PH_EVEN) && is_comma(cg);
        end
    end
endmodule

// File: rtl/idle_out_stage.sv
module idle_out_stage
    import idle_conv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cg_valid,
    input  code_group_t cg,
    input  logic        rewrite,
    input  logic        disp_pos,
    output logic        o_valid,
    output code_group_t o_cg
);
    code_group_t next_cg;

    always_comb begin
        next_cg = cg;
        if (rewrite) begin
            next_cg.k = 1'b0;
            next_cg.d = idle_second(disp_pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_cg    <= '0;
        end else begin
            o_valid <= cg_valid;
            if (cg_valid) begin
                o_cg <= next_cg;
            end
        end
    end
endmodule

// File: rtl/idle_os_converter.sv
module idle_os_converter
    import idle_conv_pkg::*;
#(
    parameter bit GUARD_CFG_CODES = 1'b1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_k,
    input  logic [CG_W-1:0]     in_data,
    input  logic                cfg_active,
    input  logic                rd_pos,
    output logic                out_valid,
    output logic                out_k,
    output logic [CG_W-1:0]     out_data
);
    code_group_t in_cg;
    code_group_t out_cg;
    cg_phase_e   phase;
    logic        rewrite;

    assign in_cg = '{k: in_k, d: in_data};

    idle_phase_track u_phase (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .phase (phase)
    );

    idle_pair_detect #(.GUARD_CFG_CODES(GUARD_CFG_CODES)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .cg_valid   (in_valid),
        .cg         (in_cg),
        .phase      (phase),
        .cfg_active (cfg_active),
        .rewrite    (rewrite)
    );

    idle_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .cg_valid (in_valid),
        .cg       (in_cg),
        .rewrite  (rewrite),
        .disp_pos (rd_pos),
        .o_valid  (out_valid),
        .o_cg     (out_cg)
    );

    assign out_k    = out_cg.k;
    assign out_data = out_cg.d;
endmodule

// File: rtl/idle_os_converter_chk.sv
module idle_os_converter_chk
    import idle_conv_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_k,
    input logic [CG_W-1:0] in_data,
    input logic            cfg_active,
    input logic            rd_pos,
    input logic            out_valid,
    input logic            out_k,
    input logic [CG_W-1:0] out_data
);
    logic settled;
    always_ff @(posedge clk) begin
        if (rst) settled <= 1'b0;
        else     settled <= 1'b1;
    end

    // R1: outputs are cleared in the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        settled == 1'b0 && rst == 1'b0 && $past(rst) |-> !out_valid && !out_k && out_data == '0);

    // R2: one-cycle latency on valid and on the control flag
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst || !settled)
        out_valid == $past(in_valid));
    a_r2_k_latency: assert property (@(posedge clk) disable iff (rst || !settled)
        $past(in_valid) && !$past(in_k) |-> !out_k);

    // R4, R5: any changed data group must be the disparity-matched idle code
    a_r5_idle_choice: assert property (@(posedge clk) disable iff (rst || !settled)
        out_valid && out_data != $past(in_data)
        |-> out_data == ($past(rd_pos) ? CG_IDLE_P : CG_IDLE_N) && !out_k);

    // R7: nothing changes while configuration is flagged
    a_r7_cfg_untouched: assert property (@(posedge clk) disable iff (rst || !settled)
        $past(in_valid) && $past(cfg_active) |-> out_data == $past(in_data));

    // R6: configuration data codes pass unchanged
    a_r6_cfg_codes: assert property (@(posedge clk) disable iff (rst || !settled)
        $past(in_valid) && !$past(in_k) && ($past(in_data) == CG_CFG_ONE || $past(in_data) == CG_CFG_TWO)
        |-> out_data == $past(in_data));

    // R9: control groups pass bit for bit
    a_r9_k_passthrough: assert property (@(posedge clk) disable iff (rst || !settled)
        $past(in_valid) && $past(in_k) |-> out_k && out_data == $past(in_data));
endmodule

bind idle_os_converter idle_os_converter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_k       (in_k),
    .in_data    (in_data),
    .cfg_active (cfg_active),
    .rd_pos     (rd_pos),
    .out_valid  (out_valid),
    .out_k      (out_k),
    .out_data   (out_data)
);

// File: tb/tb_idle_os_converter.sv
module tb_idle_os_converter;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_k = 1'b0, cfg_active = 1'b0, rd_pos = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_k;
    logic [7:0] out_data;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    bit         m_odd = 1'b0, m_armed = 1'b0, m_gap = 1'b0;
    bit         e_valid = 1'b0, e_k = 1'b0;
    logic [7:0] e_data = 8'h00;
    string      e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_os_converter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_k(in_k), .in_data(in_data),
        .cfg_active(cfg_active), .rd_pos(rd_pos),
        .out_valid(out_valid), .out_k(out_k), .out_data(out_data)
    );

    task automatic check_out();
        tests++;
        if (out_valid !== e_valid || (e_valid && (out_k !== e_k || out_data !== e_data))) begin
            fails++;
            $display("FAIL %s: got v=%0b k=%0b d=%02h, expected v=%0b k=%0b d=%02h",
                     e_tag, out_valid, out_k, out_data, e_valid, e_k, e_data);
        end
    endtask

    task automatic send(input bit v, input bit k, input logic [7:0] d, input bit cfg, input bit rd);
        @(negedge clk);
        check_out();
        in_valid = v; in_k = k; in_data = d; cfg_active = cfg; rd_pos = rd;
        if (!v) begin
            e_valid = 1'b0; e_tag = "R2";
            if (m_armed) m_gap = 1'b1;
        end else begin
            e_valid = 1'b1; e_k = k; e_data = d; e_tag = "R9";
            if (k && d == 8'hBC) e_tag = m_odd ? "R8" : "R11";
            if (m_armed && !k) begin
                if (cfg) e_tag = "R7";
                else if (d == 8'hB5 || d == 8'h42) e_tag = "R6";
                else begin
                    e_data = rd ? 8'h50 : 8'hC5;
                    e_tag = m_gap ? "R10" : (rd ? "R3/R5" : "R3/R4");
                end
            end
            m_armed = !m_odd && k && d == 8'hBC;
            m_gap = 1'b0;
            m_odd = !m_odd;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        e_valid = 1'b0; e_tag = "R1";
        tests++;
        if (out_valid !== 1'b0 || out_k !== 1'b0 || out_data !== 8'h00) begin
            fails++;
            $display("FAIL R1: got v=%0b k=%0b d=%02h, expected 0 0 00", out_valid, out_k, out_data);
        end
        rst = 1'b0;
        // first cycle after reset: outputs still clear (R1)
        send(1'b0, 0, 8'h00, 0, 0);
        // R3/R4 and R11: idle with negative disparity
        send(1, 1, 8'hBC, 0, 0);
        send(1, 0, 8'h4A, 0, 0);
        // R5: idle with positive disparity
        send(1, 1, 8'hBC, 0, 1);
        send(1, 0, 8'h4A, 0, 1);
        // R6: configuration codes
        send(1, 1, 8'hBC, 0, 1);
        send(1, 0, 8'hB5, 0, 1);
        send(1, 1, 8'hBC, 0, 0);
        send(1, 0, 8'h42, 0, 0);
        // R7: configuration flag protects any value
        send(1, 1, 8'hBC, 1, 1);
        send(1, 0, 8'h4A, 1, 1);
        // R9: ordinary data, control after comma
        send(1, 0, 8'h55, 0, 0);
        send(1, 0, 8'hC5, 0, 1);
        send(1, 1, 8'hBC, 0, 0);
        send(1, 1, 8'hF7, 0, 0);
        // R8: comma on odd position
        send(1, 0, 8'h11, 0, 0);
        send(1, 1, 8'hBC, 0, 1);
        send(1, 0, 8'h22, 0, 1);
        // R10: gaps between comma and its partner
        send(1, 0, 8'h33, 0, 0);
        send(1, 1, 8'hBC, 0, 0);
        send(0, 0, 8'h00, 0, 1);
        send(0, 0, 8'h00, 0, 1);
        send(1, 0, 8'h99, 0, 1);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom_range(0, 7) != 0);
            bit k = ($urandom_range(0, 3) == 0);
            logic [7:0] d = k ? 8'hBC : 8'($urandom);
            if ($urandom_range(0, 5) == 0) d = 8'hB5;
            send(v, k, d, ($urandom_range(0, 15) == 0), 1'($urandom));
        end
        send(0, 0, 8'h00, 0, 0);
        finish_run();
    end
endmodule